// File: doc/BRIEF.md
# I2C Slave Front End with Pin-Strapped Address

This block is the byte-level I2C target interface of a bridge device. It oversamples the bus clock and data lines with the system clock and finds START and STOP conditions. It collects the address byte and answers its own 7-bit address. The address is a fixed upper nibble of binary 0101 followed by three bits strapped on pins. The last bit of the address byte sets the transfer direction.

In a write message, every received byte goes to a downstream command controller as a one-cycle strobe with the byte. In a read message, the slave takes bytes from that controller, one at a time, and shifts them onto the bus. It keeps sending while the master acknowledges. The controller holds a busy input while it executes a command, and during that time the slave refuses its address. In low-power mode, a match on the slave's own address raises a wake strobe. The data line is only ever pulled low: the output is a pull-down enable, and a released line reads high.

Top module: `i2cStrapSlave`

## Requirements
- R1: While reset is high and right after it is released, sdaPullLow is 0, no strobe output is high, and readDir is 0.
- R2: An address byte whose upper seven bits (MSB first) equal 0101 followed by the strapped pin value is acknowledged. sdaPullLow is high during the ninth clock. Any other address gets no acknowledge, and the bytes that follow until the next START are ignored: no rxValid, no pull-down.
- R3: addrPins is sampled only while rst is high. A change on the pins after reset does not change the address. A new reset takes the new pin value.
- R4: When busy is high at the end of the address byte, the own address is not acknowledged and addrHit stays low.
- R5: The eighth bit of the address byte (1 = master reads, 0 = master writes) appears on readDir together with a one-cycle addrHit pulse when the address is acknowledged. readDir keeps its value until the next acknowledged address.
- R6: In a write message, each data byte, received MSB first, appears on rxData with a one-cycle rxValid pulse and is acknowledged.
- R7: In a read message, a byte on txData is consumed (txTake pulses) when the address is acknowledged and after each master ACK. It is sent MSB first. After a master NACK the slave releases SDA and takes no further byte.
- R8: startStb pulses once for every START, including a repeated START. A repeated START restarts address reception.
- R9: stopStb pulses on a STOP only if the slave acknowledged its address since the last START, and SDA is released at that point.
- R10: When idleMode is high, a match on the own address pulses wakeStb, even if busy refuses the acknowledge.
- R11: sdaPullLow becomes active only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Asynchronous active-high reset; also captures addrPins |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrPins | input | 3 | Strapped low address bits |
| busy | input | 1 | Command in progress; refuse the address |
| idleMode | input | 1 | Low-power mode is active |
| txData | input | 8 | Next byte to send in a read message |
| sdaPullLow | output | 1 | Pull-down enable for the data line |
| rxData | output | 8 | Received byte, valid with rxValid |
| rxValid | output | 1 | One-cycle strobe: a write byte arrived |
| txTake | output | 1 | One-cycle strobe: txData was consumed |
| startStb | output | 1 | One-cycle strobe: START seen |
| stopStb | output | 1 | One-cycle strobe: STOP ended an acknowledged session |
| addrHit | output | 1 | One-cycle strobe: own address acknowledged |
| readDir | output | 1 | Direction of the last acknowledged message (1 = read) |
| wakeStb | output | 1 | One-cycle strobe: own address seen in low-power mode |

## Verification
The wake decision and the busy refusal happen in the same cycle: the address decision at the falling clock edge after the eighth bit. The bench provokes this by holding busy and idleMode high together while the master sends the slave's own address, and by mixing both inputs at random across many messages. It judges the outcome from the ports: the master must see no acknowledge, wakeStb must pulse exactly once, and addrHit must stay quiet.

// File: rtl/i2cStrapPkg.sv
package i2cStrapPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } slvState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic countBit;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic relSda;
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic sclRise;
    logic sclFall;
    logic cntFull;
    logic addrMatch;
    logic rwBit;
    logic sdaLevel;
  } dpStat_t;

endpackage

// File: rtl/i2cStrapDatapath.sv
module i2cStrapDatapath
  import i2cStrapPkg::*;
#(
  parameter int PIN_W = 3,
  parameter int FIX_W = 4,
  parameter logic [FIX_W-1:0] FIX_ADDR = 4'b0101,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic [DATA_W-1:0] txData,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  output logic [DATA_W-1:0] shOut,
  output logic              sdaPullLow
);
  localparam int ADDR_W = FIX_W + PIN_W;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int RW_BIT = DATA_W - ADDR_W - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [PIN_W-1:0] pinLatch;
  logic [DATA_W-1:0] shReg;
  logic sdaOe;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // synchronizer chain and edge history
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  // strap capture: loaded only while reset is held
  always_ff @(posedge clk or posedge rst) begin
    if (rst) pinLatch <= addrPins;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bitCnt <= '0;
      shReg  <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (ctl.clrCnt)        bitCnt <= '0;
      else if (ctl.countBit) bitCnt <= bitCnt + 1'b1;

      if (ctl.loadTx)       shReg <= txData;
      else if (ctl.shiftTx) shReg <= {shReg[DATA_W-2:0], 1'b0};
      else if (ctl.shiftIn) shReg <= {shReg[DATA_W-2:0], sdaS};

      if (ctl.relSda)        sdaOe <= 1'b0;
      else if (ctl.driveAck) sdaOe <= 1'b1;
      else if (ctl.loadTx)   sdaOe <= ~txData[DATA_W-1];
      else if (ctl.shiftTx)  sdaOe <= ~shReg[DATA_W-2];
    end
  end

  assign stat.startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stat.stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign stat.sclRise   = sclS & ~sclPrev;
  assign stat.sclFall   = ~sclS & sclPrev;
  assign stat.cntFull   = (bitCnt == CNT_W'(DATA_W));
  assign stat.addrMatch = (shReg[DATA_W-1 -: ADDR_W] == {FIX_ADDR, pinLatch});
  assign stat.rwBit     = shReg[RW_BIT];
  assign stat.sdaLevel  = sdaS;

  assign shOut      = shReg;
  assign sdaPullLow = sdaOe;
endmodule

// File: rtl/i2cStrapControl.sv
module i2cStrapControl
  import i2cStrapPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  dpStat_t stat,
  input  logic    busy,
  input  logic    idleMode,
  output dpCtl_t  ctl,
  output logic    startStb,
  output logic    stopStb,
  output logic    addrHit,
  output logic    readDir,
  output logic    rxValid,
  output logic    txTake,
  output logic    wakeStb
);
  slvState_t state, nxt;
  logic inSession, mAck;
  logic startN, stopN, hitN, rxN, takeN, wakeN, sessN, mAckN;

  always_comb begin
    nxt    = state;
    ctl    = '0;
    startN = 1'b0;
    stopN  = 1'b0;
    hitN   = 1'b0;
    rxN    = 1'b0;
    takeN  = 1'b0;
    wakeN  = 1'b0;
    sessN  = inSession;
    mAckN  = mAck;
    if (stat.startCond) begin
      nxt        = S_ADDR;
      ctl.clrCnt = 1'b1;
      ctl.relSda = 1'b1;
      startN     = 1'b1;
      sessN      = 1'b0;
    end else if (stat.stopCond) begin
      nxt        = S_IDLE;
      ctl.relSda = 1'b1;
      stopN      = inSession;
      sessN      = 1'b0;
    end else begin
      unique case (state)
        S_ADDR: begin
          if (stat.sclRise && !stat.cntFull) begin
            ctl.shiftIn  = 1'b1;
            ctl.countBit = 1'b1;
          end else if (stat.sclFall && stat.cntFull) begin
            wakeN = stat.addrMatch & idleMode;
            if (stat.addrMatch && !busy) begin
              ctl.driveAck = 1'b1;
              hitN  = 1'b1;
              sessN = 1'b1;
              nxt   = S_AACK;
            end else begin
              nxt = S_IDLE;
            end
          end
        end
        S_AACK: if (stat.sclFall) begin
          ctl.clrCnt = 1'b1;
          if (readDir) begin
            ctl.loadTx = 1'b1;
            takeN      = 1'b1;
            nxt        = S_RD;
          end else begin
            ctl.relSda = 1'b1;
            nxt        = S_WR;
          end
        end
        S_WR: begin
          if (stat.sclRise && !stat.cntFull) begin
            ctl.shiftIn  = 1'b1;
            ctl.countBit = 1'b1;
          end else if (stat.sclFall && stat.cntFull) begin
            rxN          = 1'b1;
            ctl.driveAck = 1'b1;
            nxt          = S_WACK;
          end
        end
        S_WACK: if (stat.sclFall) begin
          ctl.relSda = 1'b1;
          ctl.clrCnt = 1'b1;
          nxt        = S_WR;
        end
        S_RD: begin
          if (stat.sclRise) ctl.countBit = 1'b1;
          else if (stat.sclFall) begin
            if (stat.cntFull) begin
              ctl.relSda = 1'b1;
              nxt        = S_RACK;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        S_RACK: begin
          if (stat.sclRise) mAckN = ~stat.sdaLevel;
          else if (stat.sclFall) begin
            if (mAck) begin
              ctl.clrCnt = 1'b1;
              ctl.loadTx = 1'b1;
              takeN      = 1'b1;
              nxt        = S_RD;
            end else begin
              nxt = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= S_IDLE;
      inSession <= 1'b0;
      mAck      <= 1'b0;
      readDir   <= 1'b0;
      startStb  <= 1'b0;
      stopStb   <= 1'b0;
      addrHit   <= 1'b0;
      rxValid   <= 1'b0;
      txTake    <= 1'b0;
      wakeStb   <= 1'b0;
    end else begin
      state     <= nxt;
      inSession <= sessN;
      mAck      <= mAckN;
      if (hitN) readDir <= stat.rwBit;
      startStb  <= startN;
      stopStb   <= stopN;
      addrHit   <= hitN;
      rxValid   <= rxN;
      txTake    <= takeN;
      wakeStb   <= wakeN;
    end
  end
endmodule

// File: rtl/i2cStrapSlave.sv
module i2cStrapSlave
  import i2cStrapPkg::*;
#(
  parameter int PIN_W = 3,
  parameter int FIX_W = 4,
  parameter logic [FIX_W-1:0] FIX_ADDR = 4'b0101,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic              busy,
  input  logic              idleMode,
  input  logic [DATA_W-1:0] txData,
  output logic              sdaPullLow,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txTake,
  output logic              startStb,
  output logic              stopStb,
  output logic              addrHit,
  output logic              readDir,
  output logic              wakeStb
);
  dpCtl_t  ctl;
  dpStat_t stat;

  i2cStrapDatapath #(
    .PIN_W(PIN_W), .FIX_W(FIX_W), .FIX_ADDR(FIX_ADDR),
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .txData(txData), .ctl(ctl), .stat(stat),
    .shOut(rxData), .sdaPullLow(sdaPullLow)
  );

  i2cStrapControl u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .busy(busy), .idleMode(idleMode),
    .ctl(ctl), .startStb(startStb), .stopStb(stopStb), .addrHit(addrHit),
    .readDir(readDir), .rxValid(rxValid), .txTake(txTake), .wakeStb(wakeStb)
  );
endmodule

// File: rtl/i2cStrapChecker.sv
module i2cStrapChecker (
  input logic clk,
  input logic rst,
  input logic sclIn,
  input logic busy,
  input logic idleMode,
  input logic sdaPullLow,
  input logic startStb,
  input logic stopStb,
  input logic addrHit,
  input logic readDir,
  input logic rxValid,
  input logic txTake,
  input logic wakeStb
);
  // R8: bus events are reported one at a time
  p_events_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startStb, stopStb, addrHit, rxValid, txTake}));

  p_busy_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    addrHit |-> !$past(busy));

  p_wake_idle_r10: assert property (@(posedge clk) disable iff (rst)
    wakeStb |-> $past(idleMode));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stopStb |-> !sdaPullLow);

  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaPullLow) |-> !sclIn);

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !addrHit |-> $stable(readDir));
endmodule

bind i2cStrapSlave i2cStrapChecker u_chk (
  .clk(clk), .rst(rst), .sclIn(sclIn), .busy(busy), .idleMode(idleMode),
  .sdaPullLow(sdaPullLow), .startStb(startStb), .stopStb(stopStb),
  .addrHit(addrHit), .readDir(readDir), .rxValid(rxValid),
  .txTake(txTake), .wakeStb(wakeStb)
);

// File: tb/i2cStrapSlave_test.sv
module i2cStrapSlave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] addrPins = 3'b101;
  logic busy = 1'b0, idleMode = 1'b0;
  logic [7:0] txData, rxData;
  logic sdaPullLow, rxValid, txTake, startStb, stopStb, addrHit, readDir, wakeStb;
  logic sdaLine;

  int checks = 0, fails = 0;
  int rxCnt = 0, takeCnt = 0, startCnt = 0, stopCnt = 0, hitCnt = 0, wakeCnt = 0;
  int pullBadCnt = 0;
  logic [7:0] rxLog [0:255];
  logic [2:0] strap = 3'b101;
  logic prevPull = 1'b0;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  function automatic logic [7:0] txByte(int k);
    return 8'(8'hA5 + k * 37);
  endfunction

  assign txData = txByte(takeCnt);

  i2cStrapSlave uut (
    .clk(clk), .rst(rst), .sclIn(sclM), .sdaIn(sdaLine), .addrPins(addrPins),
    .busy(busy), .idleMode(idleMode), .txData(txData), .sdaPullLow(sdaPullLow),
    .rxData(rxData), .rxValid(rxValid), .txTake(txTake), .startStb(startStb),
    .stopStb(stopStb), .addrHit(addrHit), .readDir(readDir), .wakeStb(wakeStb)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rxValid) begin rxLog[rxCnt & 255] <= rxData; rxCnt <= rxCnt + 1; end
      if (txTake)   takeCnt  <= takeCnt + 1;
      if (startStb) startCnt <= startCnt + 1;
      if (stopStb)  stopCnt  <= stopCnt + 1;
      if (addrHit)  hitCnt   <= hitCnt + 1;
      if (wakeStb)  wakeCnt  <= wakeCnt + 1;
      if (sdaPullLow && !prevPull && sclM) pullBadCnt <= pullBadCnt + 1;
    end
    prevPull <= sdaPullLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expAck(input logic [6:0] a);
    return (a == {4'b0101, strap}) && !busy;
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic clkBit(input logic v, output logic seen);
    sdaM = v; waitQ(); sclM = 1'b1; waitQ(); seen = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clkBit(1'b1, s); b[i] = s; end
    clkBit(!giveAck, s);
  endtask

  task automatic doReset(input logic [2:0] pins);
    rst = 1'b1; addrPins = pins; strap = pins;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int b0, t0, s0, p0, h0, w0;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(sdaPullLow == 0 && !addrHit && !rxValid && !txTake, "R1 outputs in reset", sdaPullLow, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check({startStb, stopStb, addrHit, rxValid, txTake, wakeStb, readDir, sdaPullLow} == 0,
          "R1 after reset", {startStb, stopStb, addrHit, rxValid, txTake, wakeStb, readDir, sdaPullLow}, 0);

    // R2 R5 R6 R9: own address write, three bytes
    b0 = rxCnt; p0 = stopCnt; h0 = hitCnt;
    busStart();
    sendByte({4'b0101, strap, 1'b0}, ack);
    check(ack == 1, "R2 own address ack", ack, 1);
    check(hitCnt == h0 + 1 && readDir == 0, "R5 write direction", readDir, 0);
    for (int i = 0; i < 3; i++) begin
      sendByte(8'h5A + 8'(i * 17), ack);
      check(ack == 1, "R6 data ack", ack, 1);
    end
    busStop();
    for (int i = 0; i < 3; i++)
      check(rxLog[(b0 + i) & 255] == 8'h5A + 8'(i * 17), "R6 byte value",
            rxLog[(b0 + i) & 255], 8'h5A + 8'(i * 17));
    check(rxCnt == b0 + 3, "R6 byte count", rxCnt - b0, 3);
    check(stopCnt == p0 + 1, "R9 stop after session", stopCnt - p0, 1);

    // R2 R9: foreign address, following byte ignored, no stop strobe
    b0 = rxCnt; p0 = stopCnt; h0 = hitCnt;
    busStart();
    sendByte({4'b0111, strap, 1'b0}, ack);
    check(ack == 0, "R2 foreign address nack", ack, 0);
    sendByte(8'h00, ack);
    check(ack == 0 && rxCnt == b0, "R2 byte after nack ignored", rxCnt - b0, 0);
    busStop();
    check(stopCnt == p0 && hitCnt == h0, "R9 no stop strobe without session", stopCnt - p0, 0);

    // R3: pins changed after reset have no effect
    addrPins = 3'b010;
    repeat (4) @(negedge clk);
    busStart(); sendByte({4'b0101, 3'b010, 1'b0}, ack); busStop();
    check(ack == 0, "R3 new pin value ignored", ack, 0);
    busStart(); sendByte({4'b0101, 3'b101, 1'b0}, ack); busStop();
    check(ack == 1, "R3 strapped value kept", ack, 1);

    // R4 R10: busy refuses while wake still fires
    busy = 1'b1; idleMode = 1'b1; w0 = wakeCnt; h0 = hitCnt;
    busStart(); sendByte({4'b0101, strap, 1'b0}, ack); busStop();
    check(ack == 0, "R4 busy nack", ack, 0);
    check(hitCnt == h0, "R4 no addrHit while busy", hitCnt - h0, 0);
    check(wakeCnt == w0 + 1, "R10 wake while busy", wakeCnt - w0, 1);
    busy = 1'b0; w0 = wakeCnt;
    busStart(); sendByte({4'b0110, strap, 1'b0}, ack); busStop();
    check(wakeCnt == w0, "R10 no wake for foreign address", wakeCnt - w0, 0);
    busStart(); sendByte({4'b0101, strap, 1'b0}, ack); busStop();
    check(ack == 1 && wakeCnt == w0 + 1, "R10 wake with ack", wakeCnt - w0, 1);
    idleMode = 1'b0;

    // R7 R5: read three bytes, NACK the last
    t0 = takeCnt;
    busStart();
    sendByte({4'b0101, strap, 1'b1}, ack);
    check(ack == 1 && readDir == 1, "R5 read direction", readDir, 1);
    for (int i = 0; i < 3; i++) begin
      recvByte(i < 2, rb);
      check(rb == txByte(t0 + i), "R7 read byte", rb, txByte(t0 + i));
    end
    check(sdaPullLow == 0, "R7 released after nack", sdaPullLow, 0);
    busStop();
    check(takeCnt == t0 + 3, "R7 take count", takeCnt - t0, 3);

    // R8: repeated START switches from write to read
    s0 = startCnt; b0 = rxCnt; t0 = takeCnt; p0 = stopCnt;
    busStart(); sendByte({4'b0101, strap, 1'b0}, ack); sendByte(8'h3C, ack);
    busStart(); sendByte({4'b0101, strap, 1'b1}, ack);
    check(ack == 1 && readDir == 1, "R8 address after repeated start", readDir, 1);
    recvByte(1'b0, rb);
    busStop();
    check(startCnt == s0 + 2, "R8 start count", startCnt - s0, 2);
    check(rxLog[b0 & 255] == 8'h3C && rb == txByte(t0), "R8 data across restart", rb, txByte(t0));
    check(stopCnt == p0 + 1, "R9 single stop", stopCnt - p0, 1);

    // R3: a new reset takes the new pin value
    doReset(3'b011);
    busStart(); sendByte({4'b0101, 3'b011, 1'b0}, ack); busStop();
    check(ack == 1, "R3 new strap after reset", ack, 1);

    // random messages
    for (int n = 0; n < 30; n++) begin
      logic [6:0] a;
      logic rw, e;
      int len;
      a = ($urandom % 2) ? {4'b0101, strap} : 7'($urandom);
      rw = 1'($urandom);
      len = 1 + ($urandom % 3);
      busy = (($urandom % 4) == 0);
      idleMode = (($urandom % 4) == 0);
      e = expAck(a);
      b0 = rxCnt; t0 = takeCnt; p0 = stopCnt; w0 = wakeCnt;
      busStart();
      sendByte({a, rw}, ack);
      check(ack == e, "R2 R4 random address", ack, e);
      check(wakeCnt == w0 + ((idleMode && a == {4'b0101, strap}) ? 1 : 0), "R10 random wake",
            wakeCnt - w0, (idleMode && a == {4'b0101, strap}) ? 1 : 0);
      if (ack && !rw) begin
        for (int i = 0; i < len; i++) sendByte(8'(n * 7 + i), ack);
        for (int i = 0; i < len; i++)
          check(rxLog[(b0 + i) & 255] == 8'(n * 7 + i), "R6 random byte",
                rxLog[(b0 + i) & 255], 8'(n * 7 + i));
      end else if (ack && rw) begin
        for (int i = 0; i < len; i++) begin
          recvByte(i < len - 1, rb);
          check(rb == txByte(t0 + i), "R7 random read", rb, txByte(t0 + i));
        end
        check(takeCnt == t0 + len, "R7 random take count", takeCnt - t0, len);
      end
      busStop();
      check(stopCnt == p0 + (e ? 1 : 0), "R9 random stop", stopCnt - p0, e ? 1 : 0);
    end
    busy = 1'b0; idleMode = 1'b0;

    check(pullBadCnt == 0, "R11 pull only while SCL low", pullBadCnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule